// File: doc/BRIEF.md
# Maskable Interrupt Entry and Return Controller

This block sequences interrupt entry and return for a small processor core. Each process request line has its own pending latch, so a request is held rather than dropped while interrupts are masked or while an interrupt routine is already running. At an instruction boundary where a request may be taken, the block saves the current program counter and the arithmetic indicators. It then marks a routine as active and redirects instruction fetch to the address held in its handler register.

The core's decoder passes four control operations to the block through a strobe, a two-bit code and an operand address: mask, unmask, return, and return-with-load. A plain return resumes at the saved program counter and loads its operand into the handler register, ready for the next entry. A return-with-load resumes at its operand instead and leaves the handler register unchanged. Both kinds of return give the saved indicators back to the core. When more than one request is pending, the lowest-numbered line is taken first.

Top module: `irq_seq`

## Requirements
- R1: After reset the mask flag, the in-routine flag, every pending latch, `redir_vld` and `ind_load` are all 0, and the handler register holds `HANDLER_RST`.
- R2: A pulse on `irq_req[i]` sets `pend[i]` in the next cycle. A pending latch is cleared only when its request is taken. While the mask flag is 1, no request is taken.
- R3: Operation code 2'b00 (mask) sets the mask flag. Code 2'b01 (unmask) clears it. An unmask with the flag already 0 changes nothing and produces no redirect.
- R4: A request is taken in a cycle with `boundary`=1, `op_vld`=0, the mask flag at 0, no routine active and at least one pending latch set. In the next cycle `redir_vld`=1, `ind_load`=0, `redir_addr` equals the handler register, `in_rtn`=1, and the taken latch is clear.
- R5: While a routine is active, no request is taken, even after an unmask. Pending requests stay held until a return executes.
- R6: Code 2'b10 (return) inside a routine produces in the next cycle `redir_vld`=1, `redir_addr` = the program counter saved at entry, `ind_load`=1, and `ind_out` = the indicators saved at entry. It also clears `in_rtn` and writes the operand into the handler register.
- R7: Code 2'b11 (return-with-load) inside a routine produces in the next cycle `redir_vld`=1, `redir_addr` = the operand, `ind_load`=1, `ind_out` = the saved indicators, and `in_rtn`=0. The handler register is left unchanged.
- R8: After a return, a request is taken again only if the mask flag is 0.
- R9: When several latches are pending, the one with the lowest index is taken. The others stay set.
- R10: Return codes (2'b10, 2'b11) with no routine active are ignored: no redirect occurs and the handler register is unchanged.
- R11: No request is taken in a cycle without `boundary`, or in a cycle with `op_vld`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | NSRC | Request pulses, one per source |
| boundary | input | 1 | Instruction boundary, a request may be taken here |
| op_vld | input | 1 | Control operation strobe |
| op_code | input | 2 | 00 mask, 01 unmask, 10 return, 11 return-with-load |
| op_addr | input | AW | Operand address of the operation |
| pc | input | AW | Current program counter |
| ind_in | input | IW | Current arithmetic indicators |
| redir_vld | output | 1 | One-cycle fetch redirect |
| redir_addr | output | AW | Next fetch address |
| ind_load | output | 1 | One-cycle strobe to restore the indicators |
| ind_out | output | IW | Indicator values to restore |
| mask_on | output | 1 | Mask flag |
| in_rtn | output | 1 | Interrupt routine active |
| pend | output | NSRC | Pending latches |

## Verification
The bench raises requests while the mask is set and while a routine runs. It then checks that they survive an unmask and are taken only after a return. A design that discards masked requests, or that lets an unmask reopen entry inside a routine, would miss a redirect or produce one too many. The bench uses both kinds of return and watches the address used by the next entry. A design that swaps the handler update between the two returns would jump to the wrong handler. It also tries return codes outside a routine, an unmask with no mask set, simultaneous requests, and boundaries that coincide with an operation strobe. In these cases a faulty design would show stray redirects, the wrong source taken, or an entry taken one cycle early.

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int AW = 16,
  parameter int IW = 4,
  parameter int NSRC = 4,
  parameter logic [AW-1:0] HANDLER_RST = 16'h0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            boundary,
  input  logic            op_vld,
  input  logic [1:0]      op_code,
  input  logic [AW-1:0]   op_addr,
  input  logic [AW-1:0]   pc,
  input  logic [IW-1:0]   ind_in,
  output logic            redir_vld,
  output logic [AW-1:0]   redir_addr,
  output logic            ind_load,
  output logic [IW-1:0]   ind_out,
  output logic            mask_on,
  output logic            in_rtn,
  output logic [NSRC-1:0] pend
);
  localparam logic [1:0] OP_MASK = 2'b00;
  localparam logic [1:0] OP_UNMASK = 2'b01;
  localparam logic [1:0] OP_RET = 2'b10;
  localparam logic [1:0] OP_RETLD = 2'b11;

  logic [AW-1:0]   handler_q, ret_pc_q;
  logic [IW-1:0]   ret_ind_q;
  logic [NSRC-1:0] pick;
  logic            take, do_ret, do_retld;

  assign pick     = pend & (~pend + 1'b1);
  assign take     = boundary && !op_vld && !mask_on && !in_rtn && (|pend);
  assign do_ret   = op_vld && op_code == OP_RET && in_rtn;
  assign do_retld = op_vld && op_code == OP_RETLD && in_rtn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      mask_on    <= 1'b0;
      in_rtn     <= 1'b0;
      redir_vld  <= 1'b0;
      redir_addr <= '0;
      ind_load   <= 1'b0;
      ind_out    <= '0;
      handler_q  <= HANDLER_RST;
      ret_pc_q   <= '0;
      ret_ind_q  <= '0;
    end else begin
      redir_vld <= 1'b0;
      ind_load  <= 1'b0;
      pend      <= (pend & ~(take ? pick : '0)) | irq_req;
      if (op_vld && op_code == OP_MASK)   mask_on <= 1'b1;
      if (op_vld && op_code == OP_UNMASK) mask_on <= 1'b0;
      if (take) begin
        ret_pc_q   <= pc;
        ret_ind_q  <= ind_in;
        in_rtn     <= 1'b1;
        redir_vld  <= 1'b1;
        redir_addr <= handler_q;
      end
      if (do_ret || do_retld) begin
        in_rtn     <= 1'b0;
        redir_vld  <= 1'b1;
        ind_load   <= 1'b1;
        ind_out    <= ret_ind_q;
        redir_addr <= do_ret ? ret_pc_q : op_addr;
      end
      if (do_ret) handler_q <= op_addr;
    end
  end
endmodule

module irq_seq_chk #(
  parameter int NSRC = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            redir_vld,
  input logic            ind_load,
  input logic            mask_on,
  input logic            in_rtn,
  input logic [NSRC-1:0] pend
);
  AST_ENTRY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_vld && !ind_load) |-> (in_rtn && !$past(in_rtn))); // R4
  AST_NO_ENTRY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_rtn) |-> !$past(mask_on)); // R2
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~pend) != '0) |-> $rose(in_rtn)); // R2
  AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_rtn) |-> ($countones($past(pend) & ~pend) <= 1)); // R9
  AST_RET_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
    ind_load |-> (redir_vld && !in_rtn && $past(in_rtn))); // R6
  AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rtn && $past(in_rtn)) |-> !redir_vld); // R5
endmodule

bind irq_seq irq_seq_chk #(.NSRC(NSRC)) chk_i (
  .clk(clk), .rst_n(rst_n), .redir_vld(redir_vld), .ind_load(ind_load),
  .mask_on(mask_on), .in_rtn(in_rtn), .pend(pend)
);

// File: tb/irq_seq_tb_top.sv
module irq_seq_tb_top;
  localparam int AW = 16, IW = 4, NSRC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NSRC-1:0] irq_req = '0;
  logic boundary = 1'b0, op_vld = 1'b0;
  logic [1:0] op_code = 2'b00;
  logic [AW-1:0] op_addr = '0, pc = '0;
  logic [IW-1:0] ind_in = '0;
  logic redir_vld, ind_load, mask_on, in_rtn;
  logic [AW-1:0] redir_addr;
  logic [IW-1:0] ind_out;
  logic [NSRC-1:0] pend;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  typedef struct packed { logic [AW-1:0] addr; logic ld; logic [IW-1:0] ind; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  irq_seq #(.AW(AW), .IW(IW), .NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .boundary(boundary),
    .op_vld(op_vld), .op_code(op_code), .op_addr(op_addr), .pc(pc),
    .ind_in(ind_in), .redir_vld(redir_vld), .redir_addr(redir_addr),
    .ind_load(ind_load), .ind_out(ind_out), .mask_on(mask_on),
    .in_rtn(in_rtn), .pend(pend)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected redirects
  always @(negedge clk) begin
    if (rst_n && redir_vld) begin
      if (q.size() == 0) chk(1'b0, "unexpected redirect R3/R5/R10/R11", {16'h0, redir_addr}, 32'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(redir_addr == e.addr, "redirect address R4/R6/R7", {16'h0, redir_addr}, {16'h0, e.addr});
        chk(ind_load == e.ld, "restore strobe R6/R7", {31'h0, ind_load}, {31'h0, e.ld});
        if (e.ld) chk(ind_out == e.ind, "restored indicators R6/R7", {28'h0, ind_out}, {28'h0, e.ind});
      end
    end
  end

  // one cycle: inputs set now (negedge), ends at next negedge
  task automatic cyc(input logic [NSRC-1:0] rq, input bit bnd, input bit ov,
                     input logic [1:0] oc, input logic [AW-1:0] oa);
    irq_req = rq; boundary = bnd; op_vld = ov; op_code = oc; op_addr = oa;
    @(posedge clk);
    @(negedge clk);
    irq_req = '0; boundary = 1'b0; op_vld = 1'b0;
  endtask

  task automatic expect_redir(input logic [AW-1:0] a, input bit ld, input logic [IW-1:0] ind);
    q.push_back('{addr: a, ld: ld, ind: ind});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mask_on == 0 && in_rtn == 0 && pend == 0 && redir_vld == 0 && ind_load == 0,
        "R1 reset state", {mask_on, in_rtn, pend}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: no boundary, no entry
    cyc(4'b0100, 0, 0, 2'b00, 0);
    chk(pend == 4'b0100, "R2 latch set", pend, 4'b0100);
    cyc(0, 0, 0, 2'b00, 0);
    chk(in_rtn == 0, "R11 no entry without boundary", in_rtn, 0);
    // R11: boundary together with op strobe (unmask no-op) does not enter
    cyc(0, 1, 1, 2'b01, 0);
    chk(in_rtn == 0 && pend == 4'b0100, "R11 no entry on op cycle", {in_rtn, pend}, 4'b0100);

    // R4 entry
    pc = 16'h0040; ind_in = 4'h5;
    expect_redir(16'h0100, 0, 0);
    cyc(0, 1, 0, 2'b00, 0);
    chk(in_rtn == 1 && pend == 0, "R4 entry flags", {in_rtn, pend}, 5'b10000);

    // R5 hold inside routine, even after mask/unmask
    cyc(4'b0010, 1, 0, 2'b00, 0);
    cyc(0, 1, 0, 2'b00, 0);
    chk(pend == 4'b0010 && in_rtn == 1, "R5 held in routine", {in_rtn, pend}, 5'b10010);
    cyc(0, 0, 1, 2'b00, 0);
    chk(mask_on == 1, "R3 mask sets flag", mask_on, 1);
    cyc(0, 0, 1, 2'b01, 0);
    chk(mask_on == 0, "R3 unmask clears flag", mask_on, 0);
    cyc(0, 1, 0, 2'b00, 0);
    chk(pend == 4'b0010 && in_rtn == 1, "R5 still held after unmask", {in_rtn, pend}, 5'b10010);

    // R6 return: back to saved pc, handler becomes 0200
    expect_redir(16'h0040, 1, 4'h5);
    cyc(0, 0, 1, 2'b10, 16'h0200);
    chk(in_rtn == 0, "R6 return clears routine", in_rtn, 0);
    pc = 16'h0080; ind_in = 4'hA;
    expect_redir(16'h0200, 0, 0);
    cyc(0, 1, 0, 2'b00, 0);
    chk(in_rtn == 1 && pend == 0, "R6 new handler used at entry", {in_rtn, pend}, 5'b10000);

    // R7 return-with-load while masked
    cyc(0, 0, 1, 2'b00, 0);
    expect_redir(16'h0300, 1, 4'hA);
    cyc(0, 0, 1, 2'b11, 16'h0300);
    chk(in_rtn == 0, "R7 return-with-load clears routine", in_rtn, 0);
    // R8 masked after return: requests held
    cyc(4'b1001, 1, 0, 2'b00, 0);
    cyc(0, 1, 0, 2'b00, 0);
    chk(in_rtn == 0 && pend == 4'b1001, "R8 masked after return holds", {in_rtn, pend}, 5'b01001);
    cyc(0, 0, 1, 2'b01, 0);
    // R9 lowest first, R7 handler unchanged
    pc = 16'h00C0; ind_in = 4'h3;
    expect_redir(16'h0200, 0, 0);
    cyc(0, 1, 0, 2'b00, 0);
    chk(pend == 4'b1000, "R9 lowest taken, other held", pend, 4'b1000);
    expect_redir(16'h00C0, 1, 4'h3);
    cyc(0, 0, 1, 2'b10, 16'h0200);
    pc = 16'h00D0; ind_in = 4'h6;
    expect_redir(16'h0200, 0, 0);
    cyc(0, 1, 0, 2'b00, 0);
    chk(pend == 0 && in_rtn == 1, "R9 second source taken", {in_rtn, pend}, 5'b10000);
    expect_redir(16'h00D0, 1, 4'h6);
    cyc(0, 0, 1, 2'b10, 16'h0200);

    // R10 return codes outside routine ignored
    cyc(0, 0, 1, 2'b10, 16'h0777);
    cyc(0, 0, 1, 2'b11, 16'h0555);
    chk(in_rtn == 0, "R10 no effect outside routine", in_rtn, 0);
    pc = 16'h00E0; ind_in = 4'h1;
    expect_redir(16'h0200, 0, 0);
    cyc(4'b0010, 0, 0, 2'b00, 0);
    cyc(0, 1, 0, 2'b00, 0);
    chk(in_rtn == 1, "R10 handler unchanged by ignored return", in_rtn, 1);
    expect_redir(16'h00E0, 1, 4'h1);
    cyc(0, 0, 1, 2'b10, 16'h0200);

    // R3 unmask without mask is a no-op
    cyc(4'b0100, 0, 1, 2'b01, 0);
    chk(mask_on == 0 && in_rtn == 0 && pend == 4'b0100, "R3 unmask no-op", {mask_on, in_rtn, pend}, 6'b000100);
    expect_redir(16'h0200, 0, 0);
    cyc(0, 1, 0, 2'b00, 0);
    cyc(0, 0, 0, 2'b00, 0);
    chk(q.size() == 0, "all expected redirects seen R4/R6/R7", q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (5000) @(posedge clk); chk(1'b0, "watchdog", 0, 1); end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule